// File: doc/BRIEF.md
# Banked Data Memory with Dedicated Cluster Ports and Shared Global Ports

This block is the data memory of a clustered wide-issue machine. Storage is split into banks that are interleaved on the low address bits. Each cluster owns a fixed group of banks and has one dedicated port into them. The compiler only steers an access to that port when it knows the bank, so the cluster ports never arbitrate. Every cluster can start one pipelined access per cycle, and read data returns after a fixed latency.

A small set of global ports can reach any bank. A global access always yields to a cluster access that holds the same bank in that cycle. Among the global ports, the lower-numbered port wins. A global read result lands in a per-port holding register, which carries a pending bit. A consumer signals that it wants a holding register through `g_use`. If that register is still pending, the block raises `freeze`, which stalls the whole machine. While `freeze` is high, no new cluster requests are accepted. Cluster accesses already in flight finish, the banks then free up, and the pending global access drains.

Each global port runs a two-state machine. In `G_IDLE` the port is ready, and a request causes the *accept* transition to `G_WAIT`. In this transition the request is latched and, for a read, the pending bit is set. In `G_WAIT` the port asks for its bank every cycle. When it wins, the *grant* transition returns it to `G_IDLE`: the access happens, read data is loaded into the holding register, and the pending bit clears. Without a grant, the *hold* transition keeps it in `G_WAIT`.

Top module: `bmem_top`

## Requirements
- R1: After reset, `g_ready` is all ones, while `g_pending`, `freeze`, `c_rvalid` and `c_err` are all zeros.
- R2: An address splits into a bank index in bits [3:0] and a row in bits [7:4]. Cluster c owns the banks whose bits [3:1] equal c. A cluster write is stored. A cluster read returns the stored word with `c_rvalid` high exactly two cycles after the request cycle. A write produces no `c_rvalid`.
- R3: Each cluster port accepts a new access every cycle, and back-to-back reads return back-to-back results.
- R4: A cluster request whose address bits [3:1] differ from its cluster number raises `c_err` in the same cycle and is dropped: no write and no `c_rvalid`.
- R5: A global port accepts a request while `g_ready` is high. For a read, `g_pending` is high in the next cycle. When no other access uses the bank, the holding register carries the word and `g_pending` is low from the second clock edge after the request.
- R6: A global write stores its word, and a later cluster read of that address returns it.
- R7: A cluster access in its memory cycle blocks a global access to the same bank, and the global access waits while the cluster keeps using that bank. A cluster access to a different bank does not block it.
- R8: When global ports wait on the same free bank, port 0 is served first and port 1 in the following cycle.
- R9: `freeze` is high exactly while some port has `g_use` and `g_pending` both high. It drops when the awaited word lands in the holding register.
- R10: Cluster requests presented while `freeze` is high are ignored: no write and no `c_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_valid | input | N_CL | Cluster request valid, one bit per cluster |
| c_we | input | N_CL | Cluster request is a write |
| c_addr | input | N_CL*AW | Cluster addresses, cluster c in slice c*AW |
| c_wdata | input | N_CL*DW | Cluster write data |
| c_rvalid | output | N_CL | Cluster read data valid |
| c_rdata | output | N_CL*DW | Cluster read data |
| c_err | output | N_CL | Cluster address outside its own banks |
| g_valid | input | NG | Global request valid |
| g_we | input | NG | Global request is a write |
| g_addr | input | NG*AW | Global addresses |
| g_wdata | input | NG*DW | Global write data |
| g_ready | output | NG | Global port can accept a request |
| g_use | input | NG | Consumer reads the holding register |
| g_pending | output | NG | Holding register awaits its data |
| g_hold | output | NG*DW | Holding registers |
| freeze | output | 1 | Machine-wide stall |

## Verification
The in-RTL assertions check on every cycle that:
- read data returns with the fixed latency;
- an erroneous or frozen cluster request starts no access;
- no bank is touched by two accessors in one cycle;
- the lower-numbered global port wins;
- a pending bit clears only on a grant.

Only the bench scenarios can show that the data is correct across every bank and row, both through cluster sweeps and through global sweeps. The same holds for three timing behaviours: a global access is blocked by its bank's owner but not by the neighbouring bank, the freeze itself releases the blocked bank, and the lower-priority port completes one cycle after the higher-priority one.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
    typedef enum logic {
        G_IDLE = 1'b0,
        G_WAIT = 1'b1
    } gstate_t;
endpackage

// File: rtl/bmem_bank.sv
module bmem_bank #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int ROW_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[row] <= wdata;
    end

    assign rdata = mem[row];
endmodule

// File: rtl/bmem_cport.sv
module bmem_cport #(
    parameter int CID   = 0,
    parameter int N_CL  = 8,
    parameter int BPC   = 2,
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int BANK_W = $clog2(N_CL * BPC),
    localparam int LOC_W  = $clog2(BPC),
    localparam int CL_W   = BANK_W - LOC_W,
    localparam int ROW_W  = $clog2(WORDS),
    localparam int AW     = BANK_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_v,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wd,
    input  logic              freeze,
    input  logic [BPC*DW-1:0] bank_rd,
    output logic              acc_v,
    output logic              acc_we,
    output logic [LOC_W-1:0]  acc_sel,
    output logic [ROW_W-1:0]  acc_row,
    output logic [DW-1:0]     acc_wd,
    output logic              rsp_v,
    output logic [DW-1:0]     rsp_d,
    output logic              err
);
    logic accept;

    assign err    = req_v && (req_addr[BANK_W-1:LOC_W] != CL_W'(CID));
    assign accept = req_v && !err && !freeze;

    // stage 1: request register, bank access happens in the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n) acc_v <= 1'b0;
        else        acc_v <= accept;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            acc_we  <= req_we;
            acc_sel <= req_addr[LOC_W-1:0];
            acc_row <= req_addr[AW-1:BANK_W];
            acc_wd  <= req_wd;
        end
    end

    // stage 2: read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_v <= 1'b0;
        else        rsp_v <= acc_v && !acc_we;
    end

    always_ff @(posedge clk) begin
        if (acc_v && !acc_we) rsp_d <= bank_rd[acc_sel*DW +: DW];
    end

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_v && !req_we && !err && !freeze) |-> ##2 rsp_v);
    // R4
    err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !acc_v);
    // R10
    freeze_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !acc_v);
endmodule

// File: rtl/bmem_gport.sv
module bmem_gport
    import bmem_pkg::*;
#(
    parameter int BANKS = 16,
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(WORDS),
    localparam int AW     = BANK_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_v,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wd,
    input  logic              grant,
    input  logic [DW-1:0]     rd,
    input  logic              use_i,
    output logic              ready,
    output logic              want,
    output logic [BANK_W-1:0] want_bank,
    output logic [ROW_W-1:0]  want_row,
    output logic              want_we,
    output logic [DW-1:0]     want_wd,
    output logic [DW-1:0]     hold,
    output logic              pending,
    output logic              stall
);
    gstate_t state, state_nx;
    logic    take, done;

    assign take = (state == G_IDLE) && req_v;
    assign done = (state == G_WAIT) && grant;

    always_comb begin
        state_nx = state;
        unique case (state)
            G_IDLE: if (req_v) state_nx = G_WAIT;
            G_WAIT: if (grant) state_nx = G_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= G_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        ready = (state == G_IDLE);
        want  = (state == G_WAIT);
        stall = use_i && pending;
    end

    always_ff @(posedge clk) begin
        if (take) begin
            want_bank <= req_addr[BANK_W-1:0];
            want_row  <= req_addr[AW-1:BANK_W];
            want_we   <= req_we;
            want_wd   <= req_wd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            hold    <= '0;
        end else begin
            if (take && !req_we) pending <= 1'b1;
            if (done) begin
                pending <= 1'b0;
                if (!want_we) hold <= rd;
            end
        end
    end

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_v && !req_we) |=> pending);
    // R5
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(grant));
    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (want && !grant) |=> (want && $stable(want_bank)));
endmodule

// File: rtl/bmem_top.sv
module bmem_top #(
    parameter int N_CL  = 8,
    parameter int BPC   = 2,
    parameter int WORDS = 16,
    parameter int DW    = 32,
    parameter int NG    = 2,
    localparam int BANKS  = N_CL * BPC,
    localparam int BANK_W = $clog2(BANKS),
    localparam int LOC_W  = $clog2(BPC),
    localparam int ROW_W  = $clog2(WORDS),
    localparam int AW     = BANK_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CL-1:0]    c_valid,
    input  logic [N_CL-1:0]    c_we,
    input  logic [N_CL*AW-1:0] c_addr,
    input  logic [N_CL*DW-1:0] c_wdata,
    output logic [N_CL-1:0]    c_rvalid,
    output logic [N_CL*DW-1:0] c_rdata,
    output logic [N_CL-1:0]    c_err,
    input  logic [NG-1:0]      g_valid,
    input  logic [NG-1:0]      g_we,
    input  logic [NG*AW-1:0]   g_addr,
    input  logic [NG*DW-1:0]   g_wdata,
    output logic [NG-1:0]      g_ready,
    input  logic [NG-1:0]      g_use,
    output logic [NG-1:0]      g_pending,
    output logic [NG*DW-1:0]   g_hold,
    output logic              freeze
);
    // cluster side
    logic              acc_v   [N_CL];
    logic              acc_we  [N_CL];
    logic [LOC_W-1:0]  acc_sel [N_CL];
    logic [ROW_W-1:0]  acc_row [N_CL];
    logic [DW-1:0]     acc_wd  [N_CL];
    logic [BPC*DW-1:0] cl_rd   [N_CL];

    // global side
    logic [NG-1:0]     want, grant, stall;
    logic [BANK_W-1:0] wbank [NG];
    logic [ROW_W-1:0]  wrow  [NG];
    logic              wwe   [NG];
    logic [DW-1:0]     wwd   [NG];
    logic [DW-1:0]     g_rd  [NG];

    // banks
    logic [BANKS-1:0]  cl_busy;
    logic              b_we  [BANKS];
    logic [ROW_W-1:0]  b_row [BANKS];
    logic [DW-1:0]     b_wd  [BANKS];
    logic [DW-1:0]     b_rd  [BANKS];
    logic [NG-1:0]     g_on  [BANKS];

    assign freeze = |stall;

    for (genvar c = 0; c < N_CL; c++) begin : g_cl
        bmem_cport #(.CID(c), .N_CL(N_CL), .BPC(BPC), .WORDS(WORDS), .DW(DW)) u_cport (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_v    (c_valid[c]),
            .req_we   (c_we[c]),
            .req_addr (c_addr[c*AW +: AW]),
            .req_wd   (c_wdata[c*DW +: DW]),
            .freeze   (freeze),
            .bank_rd  (cl_rd[c]),
            .acc_v    (acc_v[c]),
            .acc_we   (acc_we[c]),
            .acc_sel  (acc_sel[c]),
            .acc_row  (acc_row[c]),
            .acc_wd   (acc_wd[c]),
            .rsp_v    (c_rvalid[c]),
            .rsp_d    (c_rdata[c*DW +: DW]),
            .err      (c_err[c])
        );
        for (genvar l = 0; l < BPC; l++) begin : g_rdl
            assign cl_rd[c][l*DW +: DW] = b_rd[c*BPC + l];
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_gl
        bmem_gport #(.BANKS(BANKS), .WORDS(WORDS), .DW(DW)) u_gport (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_v     (g_valid[g]),
            .req_we    (g_we[g]),
            .req_addr  (g_addr[g*AW +: AW]),
            .req_wd    (g_wdata[g*DW +: DW]),
            .grant     (grant[g]),
            .rd        (g_rd[g]),
            .use_i     (g_use[g]),
            .ready     (g_ready[g]),
            .want      (want[g]),
            .want_bank (wbank[g]),
            .want_row  (wrow[g]),
            .want_we   (wwe[g]),
            .want_wd   (wwd[g]),
            .hold      (g_hold[g*DW +: DW]),
            .pending   (g_pending[g]),
            .stall     (stall[g])
        );
        assign g_rd[g] = b_rd[wbank[g]];
    end

    // global arbitration: cluster owners first, then ports in index order
    always_comb begin
        logic [BANKS-1:0] taken;
        taken = cl_busy;
        for (int g = 0; g < NG; g++) begin
            grant[g] = want[g] && !taken[wbank[g]];
            if (grant[g]) taken[wbank[g]] = 1'b1;
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bk
        localparam int               OWNER = b / BPC;
        localparam logic [LOC_W-1:0] LOCAL = LOC_W'(b % BPC);

        assign cl_busy[b] = acc_v[OWNER] && (acc_sel[OWNER] == LOCAL);

        always_comb begin
            for (int g = 0; g < NG; g++)
                g_on[b][g] = grant[g] && (wbank[g] == BANK_W'(b));
        end

        always_comb begin
            b_we[b]  = 1'b0;
            b_row[b] = acc_row[OWNER];
            b_wd[b]  = acc_wd[OWNER];
            if (cl_busy[b]) begin
                b_we[b] = acc_we[OWNER];
            end else begin
                for (int g = 0; g < NG; g++) begin
                    if (g_on[b][g]) begin
                        b_we[b]  = wwe[g];
                        b_row[b] = wrow[g];
                        b_wd[b]  = wwd[g];
                    end
                end
            end
        end

        bmem_bank #(.WORDS(WORDS), .DW(DW)) u_bank (
            .clk   (clk),
            .we    (b_we[b]),
            .row   (b_row[b]),
            .wdata (b_wd[b]),
            .rdata (b_rd[b])
        );

        // R7
        bank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(g_on[b]) && !(cl_busy[b] && (|g_on[b])));
    end

    for (genvar g = 1; g < NG; g++) begin : g_pr
        for (genvar h = 0; h < g; h++) begin : g_ph
            // R8
            g_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (want[g] && want[h] && (wbank[g] == wbank[h])) |-> !grant[g]);
        end
    end

    // R9
    freeze_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (|g_pending));
endmodule

// File: tb/bmem_top_tb.sv
`timescale 1ns/1ps
module bmem_top_tb;
    localparam int N_CL = 8, NG = 2, AW = 8, DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CL-1:0]    c_valid = '0, c_we = '0;
    logic [N_CL*AW-1:0] c_addr = '0;
    logic [N_CL*DW-1:0] c_wdata = '0;
    logic [N_CL-1:0]    c_rvalid, c_err;
    logic [N_CL*DW-1:0] c_rdata;
    logic [NG-1:0]      g_valid = '0, g_we = '0, g_use = '0;
    logic [NG*AW-1:0]   g_addr = '0;
    logic [NG*DW-1:0]   g_wdata = '0;
    logic [NG-1:0]      g_ready, g_pending;
    logic [NG*DW-1:0]   g_hold;
    logic              freeze;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bmem_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .c_valid(c_valid), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rvalid(c_rvalid), .c_rdata(c_rdata), .c_err(c_err),
        .g_valid(g_valid), .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata),
        .g_ready(g_ready), .g_use(g_use), .g_pending(g_pending), .g_hold(g_hold),
        .freeze(freeze)
    );

    function automatic logic [31:0] pat(input logic [7:0] a);
        return {a, ~a, a ^ 8'h5A, 8'hC3};
    endfunction

    function automatic logic [7:0] sweep_addr(input int c, input int i);
        return 8'((i / 2) * 16 + c * 2 + (i % 2));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic greq(input int p, input logic we, input logic [7:0] a, input logic [31:0] d);
        g_valid[p] = 1'b1;
        g_we[p] = we;
        g_addr[p*AW +: AW] = a;
        g_wdata[p*DW +: DW] = d;
    endtask

    task automatic cdrive(input int c, input logic we, input logic [7:0] a, input logic [31:0] d);
        c_valid[c] = 1'b1;
        c_we[c] = we;
        c_addr[c*AW +: AW] = a;
        c_wdata[c*DW +: DW] = d;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 g_ready", 32'(g_ready), 32'h3);
        check("R1 g_pending", 32'(g_pending), 32'h0);
        check("R1 freeze", 32'(freeze), 32'h0);
        check("R1 c_rvalid", 32'(c_rvalid), 32'h0);
        check("R1 c_err", 32'(c_err), 32'h0);
        rst_n = 1'b1;

        // R2/R3 fill every bank and row through the cluster ports, all clusters each cycle
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            for (int c = 0; c < N_CL; c++) cdrive(c, 1'b1, sweep_addr(c, i), pat(sweep_addr(c, i)));
            check("R2 write gives no rvalid", 32'(c_rvalid), 32'h0);
        end
        // R2/R3 read back pipelined, result two cycles after each request
        for (int i = 0; i < 34; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                for (int c = 0; c < N_CL; c++) begin
                    check("R3 rvalid", 32'(c_rvalid[c]), 32'h1);
                    check("R2 rdata", c_rdata[c*DW +: DW], pat(sweep_addr(c, i - 2)));
                end
            end
            for (int c = 0; c < N_CL; c++) begin
                if (i < 32) cdrive(c, 1'b0, sweep_addr(c, i), '0);
                else c_valid[c] = 1'b0;
            end
        end

        // R4 cluster 0 addresses bank 5 (owned by cluster 2)
        @(negedge clk);
        cdrive(0, 1'b1, 8'h05, 32'h12345678);
        #1 check("R4 err on write", 32'(c_err[0]), 32'h1);
        @(negedge clk);
        cdrive(0, 1'b0, 8'h05, '0);
        #1 check("R4 err on read", 32'(c_err[0]), 32'h1);
        @(negedge clk);
        c_valid = '0;
        @(negedge clk);
        check("R4 no rvalid", 32'(c_rvalid[0]), 32'h0);
        cdrive(2, 1'b0, 8'h05, '0);
        @(negedge clk);
        c_valid = '0;
        @(negedge clk);
        check("R4 memory untouched", c_rdata[2*DW +: DW], pat(8'h05));

        // R5 global read sweep over the whole address space, alternating ports
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            greq(a % 2, 1'b0, 8'(a), '0);
            @(negedge clk);
            g_valid = '0;
            check("R5 pending next cycle", 32'(g_pending[a % 2]), 32'h1);
            check("R5 busy", 32'(g_ready[a % 2]), 32'h0);
            @(negedge clk);
            check("R5 pending cleared", 32'(g_pending[a % 2]), 32'h0);
            check("R5 hold data", g_hold[(a % 2)*DW +: DW], pat(8'(a)));
        end

        // R6 global write, then cluster 7 reads it
        @(negedge clk);
        greq(1, 1'b1, 8'h9E, 32'hCAFEF00D);
        @(negedge clk);
        g_valid = '0;
        @(negedge clk);
        cdrive(7, 1'b0, 8'h9E, '0);
        @(negedge clk);
        c_valid = '0;
        @(negedge clk);
        check("R6 global write stored", c_rdata[7*DW +: DW], 32'hCAFEF00D);

        // R8 both ports on bank 3, port 0 first
        @(negedge clk);
        greq(0, 1'b0, 8'h43, '0);
        greq(1, 1'b0, 8'h53, '0);
        @(negedge clk);
        g_valid = '0;
        check("R8 both pending", 32'(g_pending), 32'h3);
        @(negedge clk);
        check("R8 port 0 served first", 32'(g_pending), 32'h2);
        check("R8 port 0 data", g_hold[0 +: DW], pat(8'h43));
        @(negedge clk);
        check("R8 port 1 served next", 32'(g_pending), 32'h0);
        check("R8 port 1 data", g_hold[DW +: DW], pat(8'h53));

        // R7 cluster 3 keeps using bank 6; port 0 waits on bank 6, port 1 uses bank 7
        @(negedge clk);
        cdrive(3, 1'b0, 8'h26, '0);
        @(negedge clk);
        greq(0, 1'b0, 8'h36, '0);
        greq(1, 1'b0, 8'h37, '0);
        @(negedge clk);
        g_valid = '0;
        check("R7 both pending", 32'(g_pending), 32'h3);
        @(negedge clk);
        check("R7 other bank not blocked", 32'(g_pending), 32'h1);
        check("R7 other bank data", g_hold[DW +: DW], pat(8'h37));
        repeat (3) @(negedge clk);
        check("R7 blocked while owner busy", 32'(g_pending[0]), 32'h1);
        check("R7 owner reads still flow", 32'(c_rvalid[3]), 32'h1);

        // R9/R10 consumer needs holding register 0 -> freeze releases the bank
        g_use[0] = 1'b1;
        cdrive(5, 1'b1, 8'h0A, 32'hDEADBEEF);
        #1 check("R9 freeze raised", 32'(freeze), 32'h1);
        @(negedge clk);
        c_valid[5] = 1'b0;
        check("R9 still pending", 32'(g_pending[0]), 32'h1);
        check("R9 freeze held", 32'(freeze), 32'h1);
        @(negedge clk);
        check("R9 pending drained", 32'(g_pending[0]), 32'h0);
        check("R9 freeze released", 32'(freeze), 32'h0);
        check("R9 hold data", g_hold[0 +: DW], pat(8'h36));
        check("R10 frozen read gave no rvalid", 32'(c_rvalid[3]), 32'h0);
        g_use = '0;
        c_valid = '0;
        @(negedge clk);
        cdrive(5, 1'b0, 8'h0A, '0);
        @(negedge clk);
        c_valid = '0;
        @(negedge clk);
        check("R10 frozen write ignored", c_rdata[5*DW +: DW], pat(8'h0A));
        check("R10 rvalid after thaw", 32'(c_rvalid[5]), 32'h1);

        @(negedge clk);
        summary();
    end
endmodule